// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Lockout

This block turns an asynchronous serial line into bytes. A frame is a low start bit, seven or eight data bits sent least significant first, an optional even or odd parity bit and one or two high stop bits. All bit timing comes from a baud tick running at sixteen times the bit rate. The line first passes through a two-flop synchronizer. Bits are gathered in a shift register and then moved to a data register that software reads.

Four flags describe the result: data-full, overrun, framing error and parity error. Each error type has its own rule for whether the frame reaches the data register. While any error flag is set, the receiver starts no new frame, so software must clear the flags to resume reception. One receive-interrupt enable gates both the data-full interrupt and the error interrupt. Software uses one-cycle strobes to read data and to clear flags.

Top module: `serial_rx_lockout`

## Requirements
- R1: After reset, rx_data is 0 and full, err_ovr, err_frm, err_par, irq_full and irq_err are all 0.
- R2: While idle, after the line has been seen high at a tick, a low level at a baud tick starts a frame. If the line is high again at the eighth tick after that detection, the event is dropped as a glitch, no flag changes, and the receiver returns to idle.
- R3: Each bit is sampled once, at tick 8 + 16k after start detection. Data bits fill rx_data from bit 0 upward. In seven-bit mode (cfg_seven=1) rx_data[7] reads 0.
- R4: With cfg_par_en=1, the data bits plus the parity bit must hold an even number of ones when cfg_par_odd=0, and an odd number when cfg_par_odd=1. On a mismatch err_par is set, the data is still written to rx_data, and full stays 0.
- R5: A first stop bit sampled as 0 sets err_frm, writes the data to rx_data and leaves full at 0. With cfg_two_stop=1 the second stop bit is not checked.
- R6: If full is 1 when a frame completes, err_ovr is set and rx_data keeps its earlier value.
- R7: A frame that passes every check, arriving while full is 0, is written to rx_data and sets full.
- R8: While any error flag is 1, no frame is received and rx_data does not change. Once the flags are cleared, reception resumes.
- R9: irq_full equals full AND irq_en. irq_err equals (err_ovr OR err_frm OR err_par) AND irq_en.
- R10: rd_strobe or clr_full clears full. Each of clr_ovr, clr_frm and clr_par clears only its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_seven | input | 1 | 1: seven data bits, 0: eight |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_two_stop | input | 1 | Two stop bits |
| irq_en | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | Data register read, clears full |
| clr_full | input | 1 | Clear full flag |
| clr_ovr | input | 1 | Clear overrun flag |
| clr_frm | input | 1 | Clear framing flag |
| clr_par | input | 1 | Clear parity flag |
| rx_data | output | 8 | Received data register |
| full | output | 1 | Data-full flag |
| err_ovr | output | 1 | Overrun error flag |
| err_frm | output | 1 | Framing error flag |
| err_par | output | 1 | Parity error flag |
| irq_full | output | 1 | Data-full interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The bench sends every 8-bit value without parity, which catches any swapped, stuck or shifted data bit. It then sends every 7-bit value with odd parity, which separates a correct parity computation from one that is inverted or that counts the unused top bit. Single frames follow with a corrupted parity bit, a low first stop bit and a low second stop bit, and each is checked to land in rx_data with only the expected flag. Further tests cover a second frame sent while the first is unread, a frame sent while an error flag is held, and a short low pulse. These show whether overrun keeps the old data, whether the lockout blocks reception, and whether glitches are rejected.

// File: rtl/srx_pkg.sv
package srx_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_START,
      S_DATA,
      S_PAR,
      S_STOP,
      S_STOP2
   } srx_state_e;

   // Result of one completed frame, handed from framer to status logic.
   typedef struct packed {
      logic [7:0] data;
      logic       par_ok;
      logic       stop_ok;
   } srx_frame_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("srx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[i] <= 1'b1;
         end else begin
            if (i == 0) chain[i] <= d_i;
            else        chain[i] <= chain[(i == 0) ? 0 : i-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
   import srx_pkg::*;
#(
   parameter int OVS  = 16,
   parameter int DW   = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       line_i,
   input  logic       lock_i,
   input  logic       seven_i,
   input  logic       par_en_i,
   input  logic       par_odd_i,
   input  logic       two_stop_i,
   output logic       done_o,
   output srx_frame_t frame_o
);
   localparam int CW      = $clog2(OVS);
   localparam int BW      = $clog2(DW);
   localparam int HALF_M1 = OVS/2 - 1;
   localparam int FULL_M1 = OVS - 1;

   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("srx_framer: OVS must be even and at least 4");
   end
   if (DW != 8) begin : g_bad_dw
      $error("srx_framer: DW must be 8");
   end

   srx_state_e    state;
   logic [CW-1:0] cnt;
   logic [BW-1:0] bitn;
   logic [DW-1:0] shreg;
   logic          pbit;
   logic          armed;

   logic [BW-1:0] last_bit;
   logic          bit_end;
   logic          mid_start;
   logic [DW-1:0] assembled;

   assign last_bit  = seven_i ? BW'(DW-2) : BW'(DW-1);
   assign bit_end   = tick_i && (cnt == CW'(FULL_M1));
   assign mid_start = tick_i && (cnt == CW'(HALF_M1));
   assign assembled = seven_i ? (shreg >> 1) : shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         cnt     <= '0;
         bitn    <= '0;
         shreg   <= '0;
         pbit    <= 1'b0;
         armed   <= 1'b0;
         done_o  <= 1'b0;
         frame_o <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (state)
            S_IDLE: begin
               if (tick_i) begin
                  if (lock_i) begin
                     armed <= 1'b0;
                  end else if (line_i) begin
                     armed <= 1'b1;
                  end else if (armed) begin
                     state <= S_START;
                     cnt   <= '0;
                  end
               end
            end
            S_START: begin
               if (mid_start) begin
                  cnt  <= '0;
                  bitn <= '0;
                  if (line_i) begin
                     state <= S_IDLE;
                  end else begin
                     state <= S_DATA;
                  end
               end else if (tick_i) begin
                  cnt <= cnt + 1'b1;
               end
            end
            S_DATA: begin
               if (bit_end) begin
                  cnt   <= '0;
                  shreg <= {line_i, shreg[DW-1:1]};
                  if (bitn == last_bit) begin
                     state <= par_en_i ? S_PAR : S_STOP;
                  end else begin
                     bitn <= bitn + 1'b1;
                  end
               end else if (tick_i) begin
                  cnt <= cnt + 1'b1;
               end
            end
            S_PAR: begin
               if (bit_end) begin
                  cnt   <= '0;
                  pbit  <= line_i;
                  state <= S_STOP;
               end else if (tick_i) begin
                  cnt <= cnt + 1'b1;
               end
            end
            S_STOP: begin
               if (bit_end) begin
                  cnt             <= '0;
                  done_o          <= 1'b1;
                  frame_o.data    <= assembled;
                  frame_o.stop_ok <= line_i;
                  frame_o.par_ok  <= !par_en_i || (((^assembled) ^ pbit) == par_odd_i);
                  armed           <= 1'b0;
                  state           <= two_stop_i ? S_STOP2 : S_IDLE;
               end else if (tick_i) begin
                  cnt <= cnt + 1'b1;
               end
            end
            S_STOP2: begin
               if (bit_end) begin
                  cnt   <= '0;
                  state <= S_IDLE;
               end else if (tick_i) begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // R8: a held error keeps the receiver idle
   p_lock_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE && lock_i) |=> (state == S_IDLE));

   // R3: a frame completes only after leaving the stop state
   p_done_from_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (state == S_IDLE || state == S_STOP2));
endmodule

// File: rtl/srx_status.sv
module srx_status
   import srx_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          done_i,
   input  srx_frame_t    frame_i,
   input  logic          irq_en_i,
   input  logic          rd_i,
   input  logic          clr_full_i,
   input  logic          clr_ovr_i,
   input  logic          clr_frm_i,
   input  logic          clr_par_i,
   output logic [DW-1:0] data_o,
   output logic          full_o,
   output logic          ovr_o,
   output logic          frm_o,
   output logic          par_o,
   output logic          lock_o,
   output logic          irq_full_o,
   output logic          irq_err_o
);
   logic accept;
   logic clean;

   assign accept = done_i && !full_o;
   assign clean  = frame_i.stop_ok && frame_i.par_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o <= '0;
         full_o <= 1'b0;
         ovr_o  <= 1'b0;
         frm_o  <= 1'b0;
         par_o  <= 1'b0;
      end else begin
         if (rd_i || clr_full_i) full_o <= 1'b0;
         if (clr_ovr_i)          ovr_o  <= 1'b0;
         if (clr_frm_i)          frm_o  <= 1'b0;
         if (clr_par_i)          par_o  <= 1'b0;
         if (done_i && full_o) begin
            ovr_o <= 1'b1;
         end
         if (accept) begin
            data_o <= frame_i.data;
            if (!frame_i.stop_ok) frm_o <= 1'b1;
            if (!frame_i.par_ok)  par_o <= 1'b1;
            if (clean)            full_o <= 1'b1;
         end
      end
   end

   assign lock_o     = ovr_o || frm_o || par_o;
   assign irq_full_o = full_o && irq_en_i;
   assign irq_err_o  = lock_o && irq_en_i;

   // R6: overrun keeps the old data and raises the flag
   p_ovr_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && full_o) |=> (ovr_o && $stable(data_o)));

   // R7: a clean frame sets full
   p_clean_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && clean) |=> full_o);

   // R4: parity failure flags but never sets full
   p_par_nofull_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !frame_i.par_ok) |=> (par_o && !full_o));

   // R5: stop failure flags but never sets full
   p_frm_nofull_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !frame_i.stop_ok) |=> (frm_o && !full_o));

   // R10: read or clear drops full when no frame lands
   p_clear_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_i || clr_full_i) && !done_i) |=> !full_o);

   // R9: error interrupt only rises while enabled
   p_irq_err_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_err_o) |-> irq_en_i);
endmodule

// File: rtl/serial_rx_lockout.sv
module serial_rx_lockout
   import srx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   parameter int DW          = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          baud_tick,
   input  logic          rxd,
   input  logic          cfg_seven,
   input  logic          cfg_par_en,
   input  logic          cfg_par_odd,
   input  logic          cfg_two_stop,
   input  logic          irq_en,
   input  logic          rd_strobe,
   input  logic          clr_full,
   input  logic          clr_ovr,
   input  logic          clr_frm,
   input  logic          clr_par,
   output logic [DW-1:0] rx_data,
   output logic          full,
   output logic          err_ovr,
   output logic          err_frm,
   output logic          err_par,
   output logic          irq_full,
   output logic          irq_err
);
   logic       line_s;
   logic       lock;
   logic       done;
   srx_frame_t frame;

   srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rxd),
      .q_o   (line_s)
   );

   srx_framer #(.OVS(OVS), .DW(DW)) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (baud_tick),
      .line_i     (line_s),
      .lock_i     (lock),
      .seven_i    (cfg_seven),
      .par_en_i   (cfg_par_en),
      .par_odd_i  (cfg_par_odd),
      .two_stop_i (cfg_two_stop),
      .done_o     (done),
      .frame_o    (frame)
   );

   srx_status #(.DW(DW)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .done_i     (done),
      .frame_i    (frame),
      .irq_en_i   (irq_en),
      .rd_i       (rd_strobe),
      .clr_full_i (clr_full),
      .clr_ovr_i  (clr_ovr),
      .clr_frm_i  (clr_frm),
      .clr_par_i  (clr_par),
      .data_o     (rx_data),
      .full_o     (full),
      .ovr_o      (err_ovr),
      .frm_o      (err_frm),
      .par_o      (err_par),
      .lock_o     (lock),
      .irq_full_o (irq_full),
      .irq_err_o  (irq_err)
   );
endmodule

// File: tb/serial_rx_lockout_test.sv
module serial_rx_lockout_test;
   localparam int BT = 32; // clocks per bit: tick every 2 clocks, 16 ticks

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic baud_tick = 1'b0;
   logic rxd = 1'b1;
   logic cfg_seven = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
   logic irq_en = 1'b0;
   logic rd_strobe = 1'b0, clr_full = 1'b0, clr_ovr = 1'b0, clr_frm = 1'b0, clr_par = 1'b0;
   logic [7:0] rx_data;
   logic full, err_ovr, err_frm, err_par, irq_full, irq_err;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   always @(posedge clk) baud_tick <= ~baud_tick;

   serial_rx_lockout uut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
      .cfg_seven(cfg_seven), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .cfg_two_stop(cfg_two_stop), .irq_en(irq_en), .rd_strobe(rd_strobe),
      .clr_full(clr_full), .clr_ovr(clr_ovr), .clr_frm(clr_frm), .clr_par(clr_par),
      .rx_data(rx_data), .full(full), .err_ovr(err_ovr), .err_frm(err_frm),
      .err_par(err_par), .irq_full(irq_full), .irq_err(irq_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hold_bit(input logic v);
      rxd = v;
      repeat (BT) @(negedge clk);
   endtask

   // par_flip inverts the correct parity bit; stop1/stop2 are the stop levels
   task automatic send(input logic [7:0] d, input bit par_flip,
                       input logic stop1, input logic stop2);
      int n;
      logic p;
      n = cfg_seven ? 7 : 8;
      p = cfg_par_odd;
      @(negedge clk);
      hold_bit(1'b0);
      for (int i = 0; i < n; i++) begin
         hold_bit(d[i]);
         p = p ^ d[i];
      end
      if (cfg_par_en) hold_bit(p ^ par_flip);
      hold_bit(stop1);
      if (cfg_two_stop) hold_bit(stop2);
      hold_bit(1'b1);
      hold_bit(1'b1);
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk);
      s = 1'b1;
      @(negedge clk);
      s = 1'b0;
      @(negedge clk);
   endtask

   task automatic flags(input string req, input logic f, input logic o,
                        input logic fr, input logic pa);
      chk({req, " full"}, full, f);
      chk({req, " ovr"}, err_ovr, o);
      chk({req, " frm"}, err_frm, fr);
      chk({req, " par"}, err_par, pa);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      chk("R1 data", rx_data, 0);
      flags("R1", 0, 0, 0, 0);
      chk("R1 irqs", {irq_full, irq_err}, 0);
      rst_n = 1'b1;
      repeat (BT) @(negedge clk);

      // R3/R7: all 8-bit values, no parity, one stop
      for (int v = 0; v < 256; v++) begin
         send(8'(v), 0, 1'b1, 1'b1);
         chk("R3 data 8N1", rx_data, v);
         chk("R7 full", full, 1);
         pulse(rd_strobe);
         chk("R10 read clears", full, 0);
      end

      // R4/R3: all 7-bit values, odd parity
      cfg_seven = 1'b1; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
      for (int v = 0; v < 128; v++) begin
         send(8'(v), 0, 1'b1, 1'b1);
         chk("R3 data 7O1", rx_data, v);
         flags("R4 7O1", 1, 0, 0, 0);
         pulse(clr_full);
      end

      // R4: even parity with corrupted parity bit
      cfg_seven = 1'b0; cfg_par_odd = 1'b0; irq_en = 1'b1;
      send(8'hA7, 1, 1'b1, 1'b1);
      chk("R4 data still written", rx_data, 8'hA7);
      flags("R4 bad parity", 0, 0, 0, 1);
      chk("R9 irq_err", irq_err, 1);

      // R8: frame during lockout is ignored
      send(8'h3C, 0, 1'b1, 1'b1);
      chk("R8 locked data", rx_data, 8'hA7);
      flags("R8 locked", 0, 0, 0, 1);
      pulse(clr_par);
      chk("R9 irq_err drops", irq_err, 0);
      send(8'h3C, 0, 1'b1, 1'b1);
      chk("R8 resumed data", rx_data, 8'h3C);
      flags("R8 resumed", 1, 0, 0, 0);
      chk("R9 irq_full", irq_full, 1);
      irq_en = 1'b0;
      @(negedge clk);
      chk("R9 irq_full gated", irq_full, 0);
      pulse(rd_strobe);

      // R5: framing error
      cfg_par_en = 1'b0;
      send(8'h5E, 0, 1'b0, 1'b1);
      chk("R5 data written", rx_data, 8'h5E);
      flags("R5 bad stop", 0, 0, 1, 0);
      pulse(clr_frm);
      flags("R10 clr_frm", 0, 0, 0, 0);

      // R5: second stop not checked
      cfg_two_stop = 1'b1;
      send(8'hC3, 0, 1'b1, 1'b0);
      chk("R5 2nd stop data", rx_data, 8'hC3);
      flags("R5 2nd stop", 1, 0, 0, 0);
      cfg_two_stop = 1'b0;

      // R6: overrun while full
      send(8'h11, 0, 1'b1, 1'b1);
      chk("R6 data kept", rx_data, 8'hC3);
      flags("R6 overrun", 1, 1, 0, 0);
      pulse(clr_ovr);
      flags("R10 clr_ovr only", 1, 0, 0, 0);
      pulse(clr_full);
      flags("R10 clr_full", 0, 0, 0, 0);

      // R2: short low pulse is a glitch
      @(negedge clk);
      rxd = 1'b0;
      repeat (6) @(negedge clk);
      rxd = 1'b1;
      repeat (3*BT) @(negedge clk);
      chk("R2 glitch data", rx_data, 8'hC3);
      flags("R2 glitch", 0, 0, 0, 0);
      send(8'h96, 0, 1'b1, 1'b1);
      chk("R2 after glitch", rx_data, 8'h96);
      flags("R2 after glitch", 1, 0, 0, 0);

      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule